// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block sits on the host side of an 8-bit NAND flash and turns one read request into a complete bus sequence. A request carries a row (page) address, a column, an area code, a byte count and a sequential flag. The sequencer keeps chip-enable low for the whole transaction. It writes the read-pointer command when one is needed, then drives the four address cycles and waits for the ready/busy line to report that the page is loaded. It then strobes read-enable once per byte and hands each byte to the consumer over a valid/ready interface.

A page holds 528 byte positions: 512 main bytes followed by 16 spare bytes. The area code selects where reading starts. Code 0 starts at the column in the lower main half, code 1 at the column plus 256, and codes 2 and 3 at the spare byte given by the column's low four bits. The sequencer remembers which read pointer the flash currently holds. Because of this it can leave out the command cycle when the pointer is already correct.

In sequential mode a page that runs out is followed by the next page. Inside a block the flash advances the page by itself. At a block edge the sequencer releases chip-enable and addresses the next page again. A ready/busy wait that runs too long aborts the transaction and reports an error.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, chip-enable, write-enable and read-enable are high, the sequencer accepts requests (req_ready high) and dout_valid is low.
- R2: The command byte is 00h for area 0, 01h for area 1 and 50h for areas 2 and 3. It is latched with the command-latch strobe high. Area 1 always writes its command. Areas 0, 2 and 3 write a command only when the tracked pointer differs. The pointer is "main" after reset and after a 00h or 01h command, and "spare" after 50h.
- R3: Every addressing phase has exactly four address-latch cycles in this order: column byte (for the spare areas, the column's low four bits with the upper four bits zero), then row bits 7:0, 15:8 and 23:16.
- R4: Read-enable is never pulsed before ready/busy has been seen high, at least WB_CYC cycles after the last address cycle.
- R5: Bytes arrive in page order from the start position (column, 256 + column, or 512 + column bits 3:0). dout_data holds steady while dout_valid is high and dout_ready is low, and no read-enable pulse occurs during that time.
- R6: In non-sequential mode the transfer ends after page position 527, even if the requested count is larger.
- R7: In sequential mode, inside a block, reading goes on with the next row at position 0 (areas 0 and 1) or 512 (areas 2 and 3). It goes through a new ready/busy wait but writes no command and no address.
- R8: In sequential mode, when the last page of a block (row modulo PG_PER_BLK equal to PG_PER_BLK-1) is used up, chip-enable goes high, then a command and four address cycles follow for the next row at column 0.
- R9: If ready/busy stays low for BUSY_MAX cycles, chip-enable goes high, done pulses with rd_err high and no further byte is delivered. rd_err clears when the next request is accepted.
- R10: Write-enable stays low for at least WE_LO and high for at least WE_HI cycles per cycle. Read-enable stays low for at least RE_LO and high for at least RE_HI cycles.
- R11: A request with length zero completes with a done pulse and no bus activity.
- R12: The transfer ends with a done pulse once req_len bytes have been handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Sequencer idle |
| req_row | input | 24 | Page (row) address |
| req_col | input | 8 | Start column |
| req_area | input | 2 | 0 lower main, 1 upper main, 2/3 spare |
| req_len | input | LEN_W | Bytes to read |
| req_seq | input | 1 | Continue across pages |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_err | output | 1 | Busy timeout on the last transfer |
| dout_valid | output | 1 | Read byte available |
| dout_ready | input | 1 | Consumer takes the byte |
| dout_data | output | 8 | Read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | Bus value driven to the flash |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus value from the flash |
| nand_rb | input | 1 | Ready (high) / busy (low) |

## Verification
The bench builds the block with PG_PER_BLK=4, so block crossings in sequential mode happen often under random row addresses. BUSY_MAX=200 makes the timeout abort cheap to reach with a flash model that never finishes. Short strobe widths (WE_LO=2, WE_HI=1, RE_LO=2, RE_HI=1, WB_CYC=3) keep long multi-page transfers of up to 1500 bytes inside the cycle budget. They also keep minimum-width pulses under test.

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int RE_LO      = 2,
  parameter int RE_HI      = 2,
  parameter int WB_CYC     = 4,
  parameter int BUSY_MAX   = 4000,
  parameter int PG_PER_BLK = 32,
  parameter int LEN_W      = 12
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_row,
  input  logic [7:0]       req_col,
  input  logic [1:0]       req_area,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_seq,
  output logic             done,
  output logic             rd_err,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_data,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb
);
  localparam int PGB = (PG_PER_BLK > 1) ? $clog2(PG_PER_BLK) : 1;
  localparam int TMW = $clog2(BUSY_MAX + WB_CYC + WE_LO + WE_HI + RE_LO + RE_HI + 2);
  localparam logic [9:0] LAST_POS  = 10'd527;
  localparam logic [9:0] SPARE_POS = 10'd512;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADR, S_WB, S_BSY, S_RE, S_OUT, S_GAP} st_t;

  st_t              st;
  logic             ph;
  logic [TMW-1:0]   tmr, lim;
  logic [1:0]       aidx, area;
  logic [23:0]      row;
  logic [7:0]       col_r, abyte;
  logic [9:0]       pos;
  logic [LEN_W-1:0] left;
  logic             seq, ptr_sp;

  wire tdone    = (tmr == lim);
  wire blk_last = (row[PGB-1:0] == PGB'(PG_PER_BLK - 1));
  wire need_cmd = (req_area == 2'd1) || (req_area[1] != ptr_sp);
  wire [7:0] cmd_code = area[1] ? 8'h50 : (area[0] ? 8'h01 : 8'h00);
  wire [9:0] start_pos = req_area[1] ? {6'b100000, req_col[3:0]} : {1'b0, req_area[0], req_col};

  always_comb begin
    case (st)
      S_CMD, S_ADR: lim = ph ? TMW'(WE_HI - 1) : TMW'(WE_LO - 1);
      S_RE:         lim = ph ? TMW'(RE_LO - 1) : TMW'(RE_HI - 1);
      S_WB:         lim = TMW'(WB_CYC - 1);
      S_BSY:        lim = TMW'(BUSY_MAX - 1);
      S_GAP:        lim = TMW'(WE_LO + WE_HI - 1);
      default:      lim = '0;
    endcase
  end

  always_comb begin
    case (aidx)
      2'd0:    abyte = area[1] ? {4'h0, col_r[3:0]} : col_r;
      2'd1:    abyte = row[7:0];
      2'd2:    abyte = row[15:8];
      default: abyte = row[23:16];
    endcase
  end

  assign req_ready   = (st == S_IDLE);
  assign nand_ce_n   = (st == S_IDLE) || (st == S_GAP);
  assign nand_cle    = (st == S_CMD);
  assign nand_ale    = (st == S_ADR);
  assign nand_io_oe  = nand_cle || nand_ale;
  assign nand_we_n   = !(nand_io_oe && !ph);
  assign nand_re_n   = !((st == S_RE) && ph);
  assign nand_io_out = nand_cle ? cmd_code : abyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; tmr <= '0; aidx <= '0; area <= '0;
      row <= '0; col_r <= '0; pos <= '0; left <= '0; seq <= 1'b0;
      ptr_sp <= 1'b0; done <= 1'b0; rd_err <= 1'b0;
      dout_valid <= 1'b0; dout_data <= '0;
    end else begin
      done <= 1'b0;
      tmr  <= tdone ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          rd_err <= 1'b0;
          row <= req_row; col_r <= req_col; area <= req_area;
          seq <= req_seq; left <= req_len; pos <= start_pos;
          ph <= 1'b0; aidx <= '0;
          if (req_len == '0) done <= 1'b1;
          else st <= need_cmd ? S_CMD : S_ADR;
        end
        S_CMD: if (tdone) begin
          ph <= !ph;
          if (ph) begin
            ptr_sp <= area[1];
            st <= S_ADR;
            aidx <= '0;
          end
        end
        S_ADR: if (tdone) begin
          ph <= !ph;
          if (ph) begin
            if (aidx == 2'd3) st <= S_WB;
            aidx <= aidx + 1'b1;
          end
        end
        S_WB: if (tdone) st <= S_BSY;
        S_BSY: if (nand_rb) begin
          st <= S_RE; ph <= 1'b0; tmr <= '0;
        end else if (tdone) begin
          rd_err <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end
        S_RE: if (tdone) begin
          ph <= !ph;
          if (ph) begin
            dout_data <= nand_io_in;
            dout_valid <= 1'b1;
            st <= S_OUT;
          end
        end
        S_OUT: if (dout_ready) begin
          dout_valid <= 1'b0;
          left <= left - 1'b1;
          pos  <= pos + 10'd1;
          if (left == LEN_W'(1) || (pos == LAST_POS && !seq)) begin
            done <= 1'b1; st <= S_IDLE;
          end else if (pos == LAST_POS) begin
            row <= row + 24'd1; col_r <= '0; area <= {area[1], 1'b0};
            pos <= area[1] ? SPARE_POS : 10'd0;
            ph <= 1'b0; aidx <= '0;
            st <= blk_last ? S_GAP : S_WB;
          end else st <= S_RE;
        end
        S_GAP: if (tdone) st <= S_CMD;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) dout_valid && !dout_ready |=> dout_valid && $stable(dout_data)); // R5
  AST_RE_PAUSE:   assert property (@(posedge clk) disable iff (!rst_n) dout_valid |-> nand_re_n); // R5
  AST_RE_READY:   assert property (@(posedge clk) disable iff (!rst_n) $fell(nand_re_n) |-> nand_rb && !nand_ce_n); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({nand_cle, nand_ale, !nand_re_n})); // R3
  AST_TIMEOUT_CE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_err) |-> nand_ce_n && done); // R9
  AST_DONE_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) done |-> req_ready && !dout_valid); // R12
  generate if (WE_LO > 1) begin : g_we_w
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(nand_we_n) |=> !nand_we_n); // R10
  end endgenerate
endmodule

// File: tb/test_nand_page_reader.sv
module test_nand_page_reader;
  localparam int WE_LO = 2, WE_HI = 1, RE_LO = 2, RE_HI = 1, WB_CYC = 3;
  localparam int BUSY_MAX = 200, PGB = 4, LEN_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_seq = 1'b0, rdy = 1'b0;
  logic [23:0] req_row = '0;
  logic [7:0] req_col = '0;
  logic [1:0] req_area = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, done, rd_err, dout_valid;
  logic [7:0] dout_data, io_out, io_in;
  logic ce_n, cle, ale, we_n, re_n, io_oe, rb;

  nand_page_reader #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
    .WB_CYC(WB_CYC), .BUSY_MAX(BUSY_MAX), .PG_PER_BLK(PGB), .LEN_W(LEN_W)) i_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_area(req_area), .req_len(req_len),
    .req_seq(req_seq), .done(done), .rd_err(rd_err), .dout_valid(dout_valid),
    .dout_ready(rdy), .dout_data(dout_data), .nand_ce_n(ce_n), .nand_cle(cle),
    .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_io_out(io_out),
    .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb(rb));

  int checks = 0, errors = 0;

  function automatic logic [7:0] fbyte(input logic [23:0] r, input logic [9:0] p);
    logic [7:0] m;
    m = r[7:0] * 8'd29;
    return m ^ r[15:8] ^ r[23:16] ^ (p[7:0] + 8'(p[9:8] * 61));
  endfunction

  // flash model
  logic stuck = 1'b0;
  logic prev_we = 1'b1, prev_re = 1'b1, m_busy = 1'b0;
  int   m_ptr = 0, m_nadr = 0, m_busy_cnt = 0, m_cmds = 0, m_viol_re = 0, m_viol_w = 0;
  int   we_lo_c = 0, we_hi_c = 0, re_lo_c = 0, re_hi_c = 0;
  logic [7:0]  abuf [4];
  logic [23:0] m_row = '0, m_last_row = '0;
  logic [7:0]  m_last_col = '0;
  logic [9:0]  m_pos = '0, m_base = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_busy = 1'b0; rb <= 1'b1; io_in <= '0;
    end else begin
      if (we_n) we_hi_c++; else we_lo_c++;
      if (re_n) re_hi_c++; else re_lo_c++;
      if (!prev_we && we_n) begin
        if (we_lo_c < WE_LO) m_viol_w++;
        we_lo_c = 0;
      end
      if (prev_we && !we_n) begin
        if (we_hi_c < WE_HI) m_viol_w++;
        we_hi_c = 0;
      end
      if (!prev_re && re_n) begin
        if (re_lo_c < RE_LO) m_viol_w++;
        re_lo_c = 0;
      end
      if (prev_re && !re_n) begin
        if (re_hi_c < RE_HI) m_viol_w++;
        re_hi_c = 0;
      end
      if (ce_n) begin
        m_busy = 1'b0;
      end else begin
        if (!prev_we && we_n) begin
          if (cle) begin
            m_cmds++; m_nadr = 0;
            m_ptr = (io_out == 8'h01) ? 1 : (io_out == 8'h50) ? 2 : 0;
          end else if (ale) begin
            abuf[m_nadr[1:0]] = io_out;
            m_nadr++;
            if (m_nadr == 4) begin
              m_nadr = 0;
              m_row = {abuf[3], abuf[2], abuf[1]};
              m_last_row = m_row; m_last_col = abuf[0];
              m_pos  = (m_ptr == 2) ? {6'b100000, abuf[0][3:0]} : {1'b0, m_ptr == 1, abuf[0]};
              m_base = (m_ptr == 2) ? 10'd512 : 10'd0;
              if (m_ptr == 1) m_ptr = 0;
              m_busy = 1'b1; m_busy_cnt = 12 + int'($urandom % 20);
            end
          end
        end else if (m_busy && !stuck) begin
          m_busy_cnt--;
          if (m_busy_cnt <= 0) m_busy = 1'b0;
        end
        if (prev_re && !re_n) begin
          if (m_busy) m_viol_re++;
          io_in <= fbyte(m_row, m_pos);
        end
        if (!prev_re && re_n) begin
          if (m_pos == 10'd527) begin
            m_row = m_row + 24'd1; m_pos = m_base;
            m_busy = 1'b1; m_busy_cnt = 12 + int'($urandom % 20);
          end else m_pos = m_pos + 10'd1;
        end
      end
      rb <= !m_busy;
    end
    prev_we = we_n; prev_re = re_n;
  end

  // consumer
  logic [7:0] got [2048];
  int got_n = 0;
  int rdy_pct = 75;
  always @(negedge clk) begin
    rdy = (int'($urandom % 100) < rdy_pct);
    if (rst_n && dout_valid && rdy) begin
      if (got_n < 2048) got[got_n] = dout_data;
      got_n++;
    end
  end

  // expectation
  logic [7:0] exp_b [2048];
  int exp_n, exp_cmds;
  logic exp_sp = 1'b0;
  logic [23:0] exp_row;
  logic [7:0] exp_col;

  task automatic build_exp(input logic [23:0] row, input logic [7:0] col, input logic [1:0] area,
                           input int len, input logic seq, input logic tout);
    logic [9:0] p;
    logic [23:0] r;
    logic need;
    need = (area == 2'd1) || (area[1] != exp_sp);
    exp_cmds = 0; exp_n = 0;
    if (len == 0) return;
    if (need) begin exp_cmds = 1; exp_sp = area[1]; end
    exp_row = row; exp_col = area[1] ? {4'h0, col[3:0]} : col;
    if (tout) return;
    r = row;
    p = area[1] ? {6'b100000, col[3:0]} : {1'b0, area[0], col};
    for (int i = 0; i < len; i++) begin
      exp_b[exp_n] = fbyte(r, p); exp_n++;
      if (p == 10'd527) begin
        if (!seq) break;
        if (r[1:0] == 2'(PGB - 1)) begin
          exp_cmds++; exp_row = r + 24'd1; exp_col = 8'h00;
        end
        r = r + 24'd1; p = area[1] ? 10'd512 : 10'd0;
      end else p = p + 10'd1;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic run(input logic [23:0] row, input logic [7:0] col, input logic [1:0] area,
                     input int len, input logic seq, input logic tout, input string tag);
    int cyc, bad, first_bad;
    build_exp(row, col, area, len, seq, tout);
    @(negedge clk);
    stuck = tout; got_n = 0; m_cmds = 0;
    req_row = row; req_col = col; req_area = area; req_len = LEN_W'(len); req_seq = seq;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    check(done, tag, "done pulse", int'(done), 1);
    check(rd_err == tout, tout ? "R9" : tag, "rd_err", int'(rd_err), int'(tout));
    check(got_n == exp_n, tag, "byte count", got_n, exp_n);
    bad = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got[i] !== exp_b[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    check(bad == 0, tag, "data mismatch at index", first_bad, -1);
    check(m_cmds == exp_cmds, "R2", "command cycles", m_cmds, exp_cmds);
    if (len != 0) begin
      check(m_last_row == exp_row, "R3", "row address", int'(m_last_row), int'(exp_row));
      check(m_last_col == exp_col, "R3", "column byte", int'(m_last_col), int'(exp_col));
    end
    stuck = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ce_n && we_n && re_n && req_ready && !dout_valid, "R1", "reset outputs",
          int'({ce_n, we_n, re_n, req_ready, dout_valid}), 5'b11110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(24'h000010, 8'h05, 2'd0, 40, 1'b0, 1'b0, "R5");     // pointer main after reset: no cmd (R2)
    run(24'h000123, 8'h10, 2'd1, 30, 1'b0, 1'b0, "R5");     // 01h always (R2)
    run(24'h000124, 8'hF0, 2'd0, 50, 1'b0, 1'b0, "R12");    // back on main, no cmd
    run(24'h0A0B0C, 8'h3C, 2'd2, 10, 1'b0, 1'b0, "R5");     // 50h, low nibble column
    run(24'h0A0B0D, 8'h01, 2'd3, 15, 1'b0, 1'b0, "R6");     // spare sticky, stops at 527
    run(24'h000200, 8'hFA, 2'd0, 300, 1'b0, 1'b0, "R6");    // truncated at page end
    run(24'h000201, 8'hF8, 2'd1, 40, 1'b1, 1'b0, "R7");     // sequential inside block
    run(24'h000203, 8'hFC, 2'd0, 300, 1'b1, 1'b0, "R8");    // block crossing
    run(24'h000307, 8'h00, 2'd2, 40, 1'b1, 1'b0, "R8");     // spare crossing
    run(24'h000050, 8'h00, 2'd0, 0, 1'b0, 1'b0, "R11");     // zero length
    check(m_cmds == 0 && got_n == 0, "R11", "bus activity", m_cmds + got_n, 0);
    run(24'h000051, 8'h00, 2'd2, 20, 1'b0, 1'b1, "R9");     // timeout abort
    run(24'h000052, 8'h07, 2'd2, 20, 1'b0, 1'b0, "R9");     // recovery, error cleared
    rdy_pct = 20;
    run(24'h000060, 8'h20, 2'd0, 25, 1'b0, 1'b0, "R5");     // heavy backpressure
    rdy_pct = 75;
    for (int t = 0; t < 30; t++) begin
      logic [1:0] a;
      logic s;
      int n;
      a = 2'($urandom % 4);
      s = 1'($urandom % 2);
      n = int'($urandom % 1500);
      if (t % 7 == 0) n = 0;
      run(24'($urandom), 8'($urandom), a, n, s, 1'b0, s ? "R7" : "R12");
    end
    check(m_viol_re == 0, "R4", "read strobes while busy", m_viol_re, 0);
    check(m_viol_w == 0, "R10", "strobe width violations", m_viol_w, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule